// File: doc/BRIEF.md
# SPI Receive Slave with Halt Wakeup

The block is the receive side of a serial peripheral interface slave. It sits on a chip clock much faster than the serial clock. The serial clock, select and data pins pass through synchronisers. Each frame is shifted in most significant bit first, with samples taken on rising serial-clock edges (clock idles low, data sampled on the leading edge). A completed frame lands in a data register and raises a frame-done flag. A second frame that arrives before software has cleared that flag raises an overrun flag instead. Losing the selection part-way through a frame raises a fault flag. All three flags share one interrupt output. That output is gated by an enable bit and by a global mask input.

The block follows the power state of the device. In wait mode it runs as normal, and any enabled interrupt also drives the wakeup request. In halt mode the register side is frozen. If the slave was selected at the moment halt began, it keeps receiving. A frame that completes during halt then raises a wakeup request, which stays high until the power controller acknowledges it. After such a wakeup, the next frame only serves to resynchronise and is thrown away, unless software disables the slave first.

Top module: `spi_slave_wake`

## Requirements
- R1: After reset, status_o, rdata_o, irq_o and wake_req_o are all zero.
- R2: With the slave enabled (control bit 0) and selected, eight rising edges of sck_i shift mosi_i in most significant bit first. The byte then appears on rdata_o and the frame-done flag (status bit 0) is set.
- R3: A frame that completes while the frame-done flag is set sets the overrun flag (status bit 1) and leaves rdata_o unchanged.
- R4: A data read (data_re_i) clears the frame-done and overrun flags only if a status read (stat_re_i) came earlier and saw either flag set. A data read without such a status read leaves both flags as they were.
- R5: If the selection is lost after one to seven bits of a frame, the fault flag (status bit 2) is set and the frame-done flag is not. The fault flag is cleared by a status read that saw it set, followed by a control write.
- R6: When control bit 2 (software select) is set, the slave is selected by control bit 3 being zero, whatever the level of ss_n_i. With bit 3 set, frames are ignored.
- R7: irq_o is high exactly when control bit 1 (interrupt enable) is set, gmask_i is low and at least one of the three flags is set.
- R8: While wait_i is high, reception behaves as normal, and wake_req_o follows irq_o.
- R9: If the slave is selected when halt_i rises and the interrupt enable is set, a frame completed during halt sets the frame-done flag and raises wake_req_o. wake_req_o then stays high until wake_ack_i.
- R10: If the slave is not selected when halt_i rises, frames during that halt change no flag and raise no wakeup.
- R11: A fault during halt sets the fault flag but does not raise wake_req_o.
- R12: While halt_i is high, status reads, data reads and control writes are ignored.
- R13: After leaving a halt that ended in a wakeup, status bit 3 (recovering) is set. The next completed frame is discarded without changing any flag or rdata_o, and it clears bit 3. Clearing the enable bit clears bit 3 at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chip clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | Serial clock pin |
| ss_n_i | input | 1 | Active-low select pin |
| mosi_i | input | 1 | Serial data in |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 4 | Control value: bit0 enable, bit1 interrupt enable, bit2 software select, bit3 software select level |
| stat_re_i | input | 1 | Status read strobe |
| data_re_i | input | 1 | Data read strobe |
| gmask_i | input | 1 | Global interrupt mask |
| wait_i | input | 1 | Device in wait mode |
| halt_i | input | 1 | Device in halt mode |
| wake_ack_i | input | 1 | Power controller acknowledges the wakeup |
| rdata_o | output | 8 | Received data register |
| status_o | output | 4 | bit0 frame done, bit1 overrun, bit2 fault, bit3 recovering |
| irq_o | output | 1 | Shared interrupt |
| wake_req_o | output | 1 | Wakeup request |

## Verification
The bench sends random bytes with random clear sequences and compares flags and data against a model. A design that overwrote data on overrun, or cleared flags on a data read with no status read first, would differ from the model within a few frames. Directed cases enter halt both selected and deselected, abort a frame inside halt, and try register accesses while frozen. These catch a design that wakes on a fault, wakes when it was not armed, drops the request before the acknowledge, or lets software touch state during halt. The recovery frame after a wakeup is checked by watching rdata_o stay unchanged. The early exit from recovery is checked by disabling the slave, which catches a design that keeps the discarded frame or never leaves recovery.

// File: rtl/spi_wake_pkg.sv
package spi_wake_pkg;
    typedef struct packed {
        logic ssi;
        logic ssm;
        logic ie;
        logic en;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
    localparam int ST_DONE = 0;
    localparam int ST_OVR  = 1;
    localparam int ST_MF   = 2;
    localparam int ST_REC  = 3;
    localparam int STAT_W  = 4;
endpackage

// File: rtl/spi_wake_sync.sv
module spi_wake_sync #(
    parameter int SIG_W  = 3,
    parameter int STAGES = 2,
    parameter logic [SIG_W-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SIG_W-1:0] async_i,
    output logic [SIG_W-1:0] sync_o
);
    logic [STAGES-1:0][SIG_W-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) pipe_d[i] = pipe_q[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe_q[i] <= RST_VAL;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign sync_o = pipe_q[STAGES-1];
endmodule

// File: rtl/spi_wake_rx.sv
module spi_wake_rx #(
    parameter int FRAME_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sck_s,
    input  logic               mosi_s,
    input  logic               active,
    output logic               done_o,
    output logic               abort_o,
    output logic [FRAME_W-1:0] byte_o
);
    localparam int CNT_W = (FRAME_W > 2) ? $clog2(FRAME_W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

    typedef struct packed {
        logic               sck_prev;
        logic [CNT_W-1:0]   cnt;
        logic [FRAME_W-1:0] sr;
        logic               done;
        logic               abort;
        logic [FRAME_W-1:0] byte_v;
    } rx_state_t;

    rx_state_t rx_d, rx_q;
    logic [FRAME_W-1:0] shifted;

    always_comb begin
        rx_d          = rx_q;
        rx_d.done     = 1'b0;
        rx_d.abort    = 1'b0;
        rx_d.sck_prev = sck_s;
        shifted       = {rx_q.sr[FRAME_W-2:0], mosi_s};
        if (!active) begin
            if (rx_q.cnt != '0) rx_d.abort = 1'b1;
            rx_d.cnt = '0;
        end else if (sck_s && !rx_q.sck_prev) begin
            rx_d.sr = shifted;
            if (rx_q.cnt == LAST) begin
                rx_d.done   = 1'b1;
                rx_d.byte_v = shifted;
                rx_d.cnt    = '0;
            end else begin
                rx_d.cnt = rx_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rx_q <= '0;
        else        rx_q <= rx_d;
    end

    assign done_o  = rx_q.done;
    assign abort_o = rx_q.abort;
    assign byte_o  = rx_q.byte_v;

    AST_DONE_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_q.done |-> $past(active)); // R2
endmodule

// File: rtl/spi_wake_core.sv
module spi_wake_core
    import spi_wake_pkg::*;
#(
    parameter int FRAME_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ss_n_s,
    input  logic               rx_done,
    input  logic               rx_abort,
    input  logic [FRAME_W-1:0] rx_byte,
    input  logic               ctrl_we_i,
    input  logic [CTRL_W-1:0]  ctrl_wdata_i,
    input  logic               stat_re_i,
    input  logic               data_re_i,
    input  logic               gmask_i,
    input  logic               wait_i,
    input  logic               halt_i,
    input  logic               wake_ack_i,
    output logic               active_o,
    output logic [FRAME_W-1:0] rdata_o,
    output logic [STAT_W-1:0]  status_o,
    output logic               irq_o,
    output logic               wake_req_o
);
    typedef struct packed {
        ctrl_t              ctrl;
        logic               spif;
        logic               ovr;
        logic               modf;
        logic [FRAME_W-1:0] data;
        logic               snap_rx;
        logic               snap_mf;
        logic               halt_q;
        logic               armed;
        logic               wake;
        logic               woke;
        logic               recover;
    } core_state_t;

    core_state_t st_d, st_q;
    logic halt_rise, halt_fall, sel, armed_eff, regs_ok, accept;

    always_comb begin
        halt_rise = halt_i && !st_q.halt_q;
        halt_fall = !halt_i && st_q.halt_q;
        sel       = st_q.ctrl.en && (st_q.ctrl.ssm ? !st_q.ctrl.ssi : !ss_n_s);
        armed_eff = halt_rise ? sel : st_q.armed;
        active_o  = sel && (!halt_i || armed_eff);
        regs_ok   = !halt_i;
        accept    = rx_done && !st_q.recover;

        st_d        = st_q;
        st_d.halt_q = halt_i;
        st_d.armed  = halt_i ? armed_eff : 1'b0;

        if (regs_ok && stat_re_i) begin
            st_d.snap_rx = st_q.spif || st_q.ovr;
            st_d.snap_mf = st_q.modf;
        end
        if (regs_ok && data_re_i && st_q.snap_rx) begin
            st_d.spif    = 1'b0;
            st_d.ovr     = 1'b0;
            st_d.snap_rx = 1'b0;
        end
        if (regs_ok && ctrl_we_i) begin
            st_d.ctrl = ctrl_t'(ctrl_wdata_i);
            if (st_q.snap_mf) begin
                st_d.modf    = 1'b0;
                st_d.snap_mf = 1'b0;
            end
        end

        if (rx_done && st_q.recover) st_d.recover = 1'b0;
        if (accept) begin
            if (st_d.spif) begin
                st_d.ovr = 1'b1;
            end else begin
                st_d.spif = 1'b1;
                st_d.data = rx_byte;
            end
        end
        if (rx_abort) st_d.modf = 1'b1;

        if (wake_ack_i) st_d.wake = 1'b0;
        if (halt_i && armed_eff && st_q.ctrl.ie && accept) begin
            st_d.wake = 1'b1;
            st_d.woke = 1'b1;
        end
        if (halt_fall) begin
            st_d.woke    = 1'b0;
            st_d.recover = st_q.woke;
        end
        if (!st_d.ctrl.en) st_d.recover = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        status_o          = '0;
        status_o[ST_DONE] = st_q.spif;
        status_o[ST_OVR]  = st_q.ovr;
        status_o[ST_MF]   = st_q.modf;
        status_o[ST_REC]  = st_q.recover;
        rdata_o           = st_q.data;
        irq_o             = st_q.ctrl.ie && !gmask_i && (st_q.spif || st_q.ovr || st_q.modf);
        wake_req_o        = st_q.wake || (wait_i && irq_o);
    end

    AST_OVR_AFTER_SPIF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.ovr) |-> $past(st_q.spif)); // R3
    AST_MODF_NO_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_abort && !rx_done && !st_q.wake) |=> !st_q.wake); // R11
    AST_WAKE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.wake && !wake_ack_i) |=> st_q.wake); // R9
    AST_HALT_FROZEN_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        halt_i |=> $stable(st_q.ctrl)); // R12
    AST_RECOVER_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.recover && rx_done) |=> ($stable(st_q.data) && !st_q.recover)); // R13
endmodule

// File: rtl/spi_slave_wake.sv
module spi_slave_wake
    import spi_wake_pkg::*;
#(
    parameter int FRAME_W     = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sck_i,
    input  logic               ss_n_i,
    input  logic               mosi_i,
    input  logic               ctrl_we_i,
    input  logic [3:0]         ctrl_wdata_i,
    input  logic               stat_re_i,
    input  logic               data_re_i,
    input  logic               gmask_i,
    input  logic               wait_i,
    input  logic               halt_i,
    input  logic               wake_ack_i,
    output logic [FRAME_W-1:0] rdata_o,
    output logic [3:0]         status_o,
    output logic               irq_o,
    output logic               wake_req_o
);
    logic [2:0] pins_s;
    logic       rx_done, rx_abort, active;
    logic [FRAME_W-1:0] rx_byte;

    spi_wake_sync #(.SIG_W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .async_i({sck_i, ss_n_i, mosi_i}),
        .sync_o(pins_s)
    );

    spi_wake_rx #(.FRAME_W(FRAME_W)) u_rx (
        .clk(clk), .rst_n(rst_n),
        .sck_s(pins_s[2]), .mosi_s(pins_s[0]), .active(active),
        .done_o(rx_done), .abort_o(rx_abort), .byte_o(rx_byte)
    );

    spi_wake_core #(.FRAME_W(FRAME_W)) u_core (
        .clk(clk), .rst_n(rst_n),
        .ss_n_s(pins_s[1]),
        .rx_done(rx_done), .rx_abort(rx_abort), .rx_byte(rx_byte),
        .ctrl_we_i(ctrl_we_i), .ctrl_wdata_i(ctrl_wdata_i),
        .stat_re_i(stat_re_i), .data_re_i(data_re_i),
        .gmask_i(gmask_i), .wait_i(wait_i), .halt_i(halt_i), .wake_ack_i(wake_ack_i),
        .active_o(active), .rdata_o(rdata_o), .status_o(status_o),
        .irq_o(irq_o), .wake_req_o(wake_req_o)
    );
endmodule

// File: tb/sim_spi_slave_wake.sv
module sim_spi_slave_wake;
    logic clk = 0, rst_n = 0;
    logic sck = 0, ss_n = 1, mosi = 0;
    logic ctrl_we = 0, stat_re = 0, data_re = 0;
    logic [3:0] ctrl_wdata = 0;
    logic gmask = 0, wait_m = 0, halt = 0, wake_ack = 0;
    logic [7:0] rdata;
    logic [3:0] status;
    logic irq, wake_req;

    int checks = 0, errors = 0;
    bit finished = 0;

    // reference model
    bit m_spif, m_ovr, m_modf, m_rec, m_snap_rx, m_snap_mf;
    logic [7:0] m_data;
    logic [3:0] m_ctrl;

    always #5 clk = ~clk;

    spi_slave_wake u0 (
        .clk(clk), .rst_n(rst_n), .sck_i(sck), .ss_n_i(ss_n), .mosi_i(mosi),
        .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wdata), .stat_re_i(stat_re),
        .data_re_i(data_re), .gmask_i(gmask), .wait_i(wait_m), .halt_i(halt),
        .wake_ack_i(wake_ack), .rdata_o(rdata), .status_o(status),
        .irq_o(irq), .wake_req_o(wake_req)
    );

    function automatic logic [3:0] exp_status();
        return {m_rec, m_modf, m_ovr, m_spif};
    endfunction

    function automatic logic exp_irq();
        return m_ctrl[1] && !gmask && (m_spif || m_ovr || m_modf);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic chk_all(input string req);
        chk({req, " status"}, 32'(status), 32'(exp_status()));
        chk({req, " rdata"}, 32'(rdata), 32'(m_data));
        chk({req, " irq"}, 32'(irq), 32'(exp_irq()));
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic stat_read(input bit model);
        @(negedge clk) stat_re = 1;
        @(negedge clk) stat_re = 0;
        if (model) begin
            m_snap_rx = m_spif | m_ovr;
            m_snap_mf = m_modf;
        end
    endtask

    task automatic data_read(input bit model);
        @(negedge clk) data_re = 1;
        @(negedge clk) data_re = 0;
        if (model && m_snap_rx) begin
            m_spif = 0; m_ovr = 0; m_snap_rx = 0;
        end
    endtask

    task automatic ctrl_write(input logic [3:0] v, input bit model);
        @(negedge clk) begin ctrl_we = 1; ctrl_wdata = v; end
        @(negedge clk) ctrl_we = 0;
        if (model) begin
            m_ctrl = v;
            if (m_snap_mf) begin m_modf = 0; m_snap_mf = 0; end
            if (!v[0]) m_rec = 0;
        end
        ticks(2);
    endtask

    task automatic clock_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            mosi = b[i];
            ticks(8); sck = 1;
            ticks(8); sck = 0;
        end
        ticks(10);
    endtask

    task automatic sel_low();  ss_n = 0; ticks(6); endtask
    task automatic sel_high(); ss_n = 1; ticks(8); endtask

    // model effect of one full accepted frame
    task automatic model_frame(input logic [7:0] b);
        if (m_rec) m_rec = 0;
        else if (m_spif) m_ovr = 1;
        else begin m_spif = 1; m_data = b; end
    endtask

    task automatic full_frame(input logic [7:0] b);
        sel_low(); clock_bits(b, 8); sel_high();
        model_frame(b);
    endtask

    task automatic clear_all();
        stat_read(1); data_read(1); ctrl_write(m_ctrl, 1); ticks(2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed;
        logic [7:0] b, hold;
        seed = 32'h5eed_1234;
        void'($urandom(seed));
        m_spif = 0; m_ovr = 0; m_modf = 0; m_rec = 0; m_snap_rx = 0; m_snap_mf = 0;
        m_data = 0; m_ctrl = 0;
        ticks(4);
        // R1 reset state
        chk("R1 status", 32'(status), 0);
        chk("R1 rdata", 32'(rdata), 0);
        chk("R1 irq", 32'(irq), 0);
        chk("R1 wake", 32'(wake_req), 0);
        rst_n = 1;
        ticks(3);
        chk("R1 status after release", 32'(status), 0);

        // R2 basic frame, MSB first
        ctrl_write(4'b0011, 1);
        full_frame(8'hA5);
        chk_all("R2 frame A5");
        // R3 overrun keeps first byte
        full_frame(8'h3C);
        chk_all("R3 overrun");
        // R4 data read without status read does not clear
        data_read(1);
        ticks(2);
        chk_all("R4 data read alone");
        stat_read(1); data_read(1); ticks(2);
        chk_all("R4 clear sequence");

        // R5 fault on lost select mid frame
        sel_low(); clock_bits(8'hFF, 3); sel_high();
        m_modf = 1;
        chk_all("R5 fault set");
        ctrl_write(4'b0011, 1);
        chk_all("R5 write without status read");
        stat_read(1); ctrl_write(4'b0011, 1);
        chk_all("R5 fault cleared");

        // R7 mask gating
        full_frame(8'h81);
        gmask = 1; ticks(2);
        chk_all("R7 masked");
        gmask = 0; ticks(2);
        chk_all("R7 unmasked");
        clear_all();

        // R6 software select
        ctrl_write(4'b0111, 1);
        ss_n = 1;
        clock_bits(8'h5A, 8);
        model_frame(8'h5A);
        chk_all("R6 soft select low");
        clear_all();
        ctrl_write(4'b1111, 1);
        sel_low(); clock_bits(8'hC3, 8); sel_high();
        chk_all("R6 soft select high ignores");
        ctrl_write(4'b0011, 1);

        // R8 wait mode
        wait_m = 1;
        full_frame(8'h77);
        chk_all("R8 wait frame");
        chk("R8 wake follows irq", 32'(wake_req), 1);
        gmask = 1; ticks(2);
        chk("R8 wake masked", 32'(wake_req), 0);
        gmask = 0; wait_m = 0; ticks(2);
        chk("R8 wake after wait", 32'(wake_req), 0);
        clear_all();

        // R10 halt entered deselected
        ss_n = 1; ticks(4);
        halt = 1; ticks(4);
        sel_low(); clock_bits(8'h99, 8); sel_high();
        chk_all("R10 no flag in unarmed halt");
        chk("R10 no wake", 32'(wake_req), 0);
        halt = 0; ticks(4);
        chk_all("R10 after exit");

        // R11 fault in armed halt does not wake
        sel_low();
        halt = 1; ticks(4);
        clock_bits(8'hF0, 3); sel_high();
        m_modf = 1;
        chk("R11 fault flag", 32'(status), 32'(exp_status()));
        chk("R11 no wake", 32'(wake_req), 0);
        halt = 0; ticks(4);
        chk_all("R11 no recovery");
        stat_read(1); ctrl_write(4'b0011, 1);
        chk_all("R11 cleared");

        // R9 armed halt wake, R12 frozen, R13 recovery
        sel_low();
        halt = 1; ticks(4);
        clock_bits(8'h6B, 8);
        model_frame(8'h6B);
        chk("R9 spif in halt", 32'(status), 32'(exp_status()));
        chk("R9 wake raised", 32'(wake_req), 1);
        ticks(30);
        chk("R9 wake held", 32'(wake_req), 1);
        stat_read(0); data_read(0); ctrl_write(4'b0000, 0);
        chk("R12 reads ignored in halt", 32'(status), 32'(exp_status()));
        chk("R12 ctrl write ignored", 32'(wake_req), 1);
        @(negedge clk) wake_ack = 1;
        @(negedge clk) wake_ack = 0;
        ticks(2);
        chk("R9 wake cleared by ack", 32'(wake_req), 0);
        halt = 0; ticks(4);
        sel_high();
        m_rec = 1;
        chk_all("R13 recovering set");
        stat_read(1); data_read(1); ticks(2);
        hold = m_data;
        full_frame(8'hE7);
        chk_all("R13 recovery frame discarded");
        chk("R13 rdata unchanged", 32'(rdata), 32'(hold));
        full_frame(8'h42);
        chk_all("R13 normal after recovery");
        clear_all();

        // R13 leaving slave mode ends recovery at once
        sel_low();
        halt = 1; ticks(4);
        clock_bits(8'h11, 8);
        model_frame(8'h11);
        @(negedge clk) wake_ack = 1;
        @(negedge clk) wake_ack = 0;
        halt = 0; ticks(4);
        sel_high();
        m_rec = 1;
        chk_all("R13 recovering again");
        ctrl_write(4'b0010, 1);
        chk_all("R13 disable clears recovery");
        ctrl_write(4'b0011, 1);
        clear_all();

        // random traffic: R2 R3 R4 R7
        for (int it = 0; it < 50; it++) begin
            int act;
            b = 8'($urandom);
            act = int'($urandom % 4);
            if (act == 0) begin stat_read(1); data_read(1); end
            else if (act == 1) data_read(1);
            else if (act == 2) stat_read(1);
            gmask = 1'($urandom);
            full_frame(b);
            chk_all("R2 R3 R4 R7 random");
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule